// File: doc/BRIEF.md
# Label-Filtered Receive Word Queue

This block sits behind a serial word receiver. Each time the receiver flags a finished 32-bit word, the block decides whether to keep it. Two optional filters make that decision. The first compares the word's 8-bit label field with a small programmable table of labels. The second compares two decode bits with two programmed values. Kept words go into a 32-entry first-in first-out queue. The host side sees three level flags: something to read, at least half full, and full.

The host reads each 32-bit word as two 16-bit halves, chosen by a half-select input. The queue moves on to the next word only when a read of the second half ends. Two bit layouts are available for the halves. The plain layout gives the word in bit order. The scrambled layout places the label next to the decode and parity bits in the first half.

A label-table mode bit lets the host fill all 16 table entries and read them back, one entry per access, in a fixed order. While this mode is on, the receive side is frozen.

Top module: `rx_label_fifo`

Serial bits are numbered 1 to 32, and serial bit n is `rx_word[n-1]`.

## Requirements
- R1: When `cfg_lbl_en`=1, a word is kept only if `rx_word[7:0]` equals one of the 16 stored labels. Each label bit k is compared with `rx_word[k]`. The value 00h matches in the same way as any other value, and the scramble setting has no effect on the comparison.
- R2: When `cfg_dec_en`=1, a word is kept only if `rx_word[8]`==`cfg_dec_b9` and `rx_word[9]`==`cfg_dec_b10`. If both filters are enabled, both must pass. If both are disabled, every word flagged by `rx_eos` is kept.
- R3: A 0-to-1 change of `cfg_lbl_mode` starts a new table sequence. The following 16 `host_wr` pulses write `host_wdata` into table entries 0 to 15 in order. Any further writes are ignored.
- R4: In the same sequence, the following 16 host reads return the entries in the same order on `rd_data`, with the entry in bits [7:0] and zeros in bits [15:8]. Each read moves to the next entry when `host_rd` falls.
- R5: While `cfg_lbl_mode`=1, no received word is stored, and host reads remove nothing from the queue.
- R6: The queue holds 32 words. A word kept while the queue is full replaces the most recently stored word, and the queue stays full.
- R7: `data_ready` is 1 when the queue holds at least 1 word. `half_full` is 1 at 16 words or more. `full` is 1 at exactly 32 words. Each flag reflects a stored word in the cycle after the clock edge that sampled `rx_eos`.
- R8: `host_sel`=0 reads the first half of the oldest word and `host_sel`=1 reads the second half. The oldest word is removed on the falling edge of a `host_rd` read of the second half. A read of the first half never removes it.
- R9: When `cfg_plain`=1, the first half is `rx_word[15:0]` and the second half is `rx_word[31:16]`.
- R10: When `cfg_plain`=0, the first half, from data bit 15 down to data bit 0, carries serial bits 13, 12, 11, 10, 9, 31, 30, 32, 1, 2, 3, 4, 5, 6, 7, 8. The second half carries serial bits 29 down to 14.
- R11: A read of an empty queue outside label mode leaves `rd_data` at its previous value and changes no flag or queue position.
- R12: Reset empties the queue and clears `rd_data` and all flags. The label table keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_word | input | 32 | Received word, serial bit n on bit n-1 |
| rx_eos | input | 1 | One-cycle strobe marking a finished word |
| cfg_lbl_en | input | 1 | Enable the label filter |
| cfg_dec_en | input | 1 | Enable the decode-bit filter |
| cfg_dec_b9 | input | 1 | Required value of serial bit 9 |
| cfg_dec_b10 | input | 1 | Required value of serial bit 10 |
| cfg_lbl_mode | input | 1 | Label-table access mode |
| cfg_plain | input | 1 | 1 = plain half layout, 0 = scrambled layout |
| host_rd | input | 1 | Host read enable, active high for one or more cycles |
| host_sel | input | 1 | Half select for reads |
| host_wr | input | 1 | Host write pulse, one cycle, for table loading |
| host_wdata | input | 8 | Label value written by the host |
| rd_data | output | 16 | Registered read data |
| data_ready | output | 1 | Queue not empty |
| half_full | output | 1 | Queue holds 16 words or more |
| full | output | 1 | Queue holds 32 words |

## Verification
Some properties are checked on every cycle:
- the flags stay consistent with each other;
- the queue stays full as long as nothing is removed;
- the fill level is frozen while label mode is on;
- `rd_data` holds while the queue is empty;
- a word is removed only right after a second-half read ends.

Other behaviour can only be shown by the bench's scenarios, which compare against a reference model of the queue:
- which words the label and decode filters accept;
- the order of table loading and readback;
- the exact bit positions of both half layouts;
- which word the overwrite replaces;
- that the label table keeps its contents through reset.

// File: rtl/rxlf_pkg.sv
`timescale 1ns/1ps
package rxlf_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int LBL_W  = 8;

  // Scrambled first half: decode/SSM-style bits high, label reversed low.
  function automatic logic [HALF_W-1:0] scr_first(input logic [WORD_W-1:0] w);
    return {w[12], w[11], w[10], w[9], w[8], w[30], w[29], w[31],
            w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7]};
  endfunction

  function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                  input logic sel, input logic plain);
    if (plain) return sel ? w[31:16] : w[15:0];
    return sel ? w[28:13] : scr_first(w);
  endfunction

  function automatic logic word_ok(input logic lbl_en, input logic lbl_hit,
                                   input logic dec_en, input logic b9, input logic b10,
                                   input logic [WORD_W-1:0] w);
    logic lbl_pass, dec_pass;
    lbl_pass = !lbl_en || lbl_hit;
    dec_pass = !dec_en || ((w[8] == b9) && (w[9] == b10));
    return lbl_pass && dec_pass;
  endfunction
endpackage

// File: rtl/rxlf_label_mem.sv
`timescale 1ns/1ps
module rxlf_label_mem #(
  parameter int LBL_N = 16,
  parameter int LW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          wr,
  input  logic [LW-1:0] wdata,
  input  logic          rd_step,
  input  logic [LW-1:0] probe,
  output logic          hit,
  output logic [LW-1:0] rd_label,
  output logic          rd_avail
);
  localparam int AW = (LBL_N > 1) ? $clog2(LBL_N) : 1;
  localparam int IW = $clog2(LBL_N + 1);
  localparam logic [IW-1:0] SEQ_END = IW'(LBL_N);

  logic [LW-1:0] lab [LBL_N];
  logic          mode_q;
  logic [IW-1:0] widx, ridx;
  logic          seq_start, wr_take;
  logic [LBL_N-1:0] match;

  assign seq_start = mode && !mode_q;
  assign wr_take   = mode && mode_q && wr && (widx < SEQ_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      widx   <= SEQ_END;
      ridx   <= SEQ_END;
    end else begin
      mode_q <= mode;
      if (seq_start) begin
        widx <= '0;
        ridx <= '0;
      end else begin
        if (wr_take) widx <= widx + IW'(1);
        if (mode && rd_step && (ridx < SEQ_END)) ridx <= ridx + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) lab[widx[AW-1:0]] <= wdata;
  end

  for (genvar i = 0; i < LBL_N; i++) begin : g_cmp
    assign match[i] = (lab[i] == probe);
  end
  assign hit = |match;

  assign rd_avail = (ridx < SEQ_END);
  assign rd_label = rd_avail ? lab[ridx[AW-1:0]] : '0;
endmodule

// File: rtl/rxlf_fifo.sv
`timescale 1ns/1ps
module rxlf_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                din,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, last_w;
  logic          is_full, ovw, adv;

  assign is_full = (count == CNT_FULL);
  assign ovw     = push && is_full && !pop;
  assign adv     = push && !ovw;
  assign last_w  = wptr - AW'(1);
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (ovw)      mem[last_w] <= din;
    else if (adv) mem[wptr]   <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (adv) wptr <= wptr + AW'(1);
      if (pop) rptr <= rptr + AW'(1);
      case ({adv, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_label_fifo.sv
`timescale 1ns/1ps
module rx_label_fifo #(
  parameter int DEPTH = 32,
  parameter int LBL_N = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rx_word,
  input  logic        rx_eos,
  input  logic        cfg_lbl_en,
  input  logic        cfg_dec_en,
  input  logic        cfg_dec_b9,
  input  logic        cfg_dec_b10,
  input  logic        cfg_lbl_mode,
  input  logic        cfg_plain,
  input  logic        host_rd,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [15:0] rd_data,
  output logic        data_ready,
  output logic        half_full,
  output logic        full
);
  import rxlf_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

  logic              rd_q, sel_q, rd_fall;
  logic              lbl_hit, lbl_avail;
  logic [LBL_W-1:0]  lbl_out;
  logic [WORD_W-1:0] head;
  logic [CW-1:0]     fill_cnt;
  logic              store_ev, pop_ev, not_empty;

  assign rd_fall   = rd_q && !host_rd;
  assign not_empty = (fill_cnt != '0);
  assign store_ev  = rx_eos && !cfg_lbl_mode &&
                     word_ok(cfg_lbl_en, lbl_hit, cfg_dec_en, cfg_dec_b9, cfg_dec_b10, rx_word);
  assign pop_ev    = rd_fall && sel_q && !cfg_lbl_mode && not_empty;

  rxlf_label_mem #(.LBL_N(LBL_N), .LW(LBL_W)) u_lbl (
    .clk(clk), .rst_n(rst_n), .mode(cfg_lbl_mode), .wr(host_wr), .wdata(host_wdata),
    .rd_step(rd_fall), .probe(rx_word[7:0]), .hit(lbl_hit),
    .rd_label(lbl_out), .rd_avail(lbl_avail)
  );

  rxlf_fifo #(.DEPTH(DEPTH), .DW(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(store_ev), .pop(pop_ev),
    .din(rx_word), .head(head), .count(fill_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      sel_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_q <= host_rd;
      if (host_rd) begin
        sel_q <= host_sel;
        if (cfg_lbl_mode) begin
          if (lbl_avail) rd_data <= {{(HALF_W-LBL_W){1'b0}}, lbl_out};
        end else if (not_empty) begin
          rd_data <= pick_half(head, host_sel, cfg_plain);
        end
      end
    end
  end

  assign data_ready = not_empty;
  assign half_full  = (fill_cnt >= CNT_HALF);
  assign full       = (fill_cnt == CNT_FULL);
endmodule

// File: rtl/rxlf_checks.sv
`timescale 1ns/1ps
module rxlf_checks #(
  parameter int DEPTH = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_lbl_mode,
  input logic                       host_rd,
  input logic                       host_sel,
  input logic [15:0]                rd_data,
  input logic                       data_ready,
  input logic                       half_full,
  input logic                       full,
  input logic                       pop_ev,
  input logic [$clog2(DEPTH+1)-1:0] fill_cnt
);
  a_r7_flag_order: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (half_full && data_ready));

  a_r6_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_ev) |=> full);

  a_r5_frozen_fill: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lbl_mode |=> $stable(fill_cnt));

  a_r11_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && !cfg_lbl_mode) |=> $stable(rd_data));

  a_r8_pop_after_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |-> ($past(host_rd) && $past(host_sel) && !host_rd && data_ready));
endmodule

bind rx_label_fifo rxlf_checks #(.DEPTH(DEPTH)) u_checks (
  .clk(clk), .rst_n(rst_n), .cfg_lbl_mode(cfg_lbl_mode), .host_rd(host_rd),
  .host_sel(host_sel), .rd_data(rd_data), .data_ready(data_ready),
  .half_full(half_full), .full(full), .pop_ev(pop_ev), .fill_cnt(fill_cnt)
);

// File: tb/tb_rx_label_fifo.sv
`timescale 1ns/1ps
module tb_rx_label_fifo;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, rx_eos, cfg_lbl_en, cfg_dec_en, cfg_dec_b9, cfg_dec_b10;
  logic        cfg_lbl_mode, cfg_plain, host_rd, host_sel, host_wr;
  logic [31:0] rx_word;
  logic [7:0]  host_wdata;
  logic [15:0] rd_data;
  logic        data_ready, half_full, full;

  rx_label_fifo dut (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_eos(rx_eos),
    .cfg_lbl_en(cfg_lbl_en), .cfg_dec_en(cfg_dec_en), .cfg_dec_b9(cfg_dec_b9),
    .cfg_dec_b10(cfg_dec_b10), .cfg_lbl_mode(cfg_lbl_mode), .cfg_plain(cfg_plain),
    .host_rd(host_rd), .host_sel(host_sel), .host_wr(host_wr), .host_wdata(host_wdata),
    .rd_data(rd_data), .data_ready(data_ready), .half_full(half_full), .full(full)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0]  labels [16];
  logic [31:0] q [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int i, input logic [7:0] lbl);
    logic [31:0] h;
    h = 32'(i) * 32'h9E3779B1 + 32'h0BADF00D;
    return {h[31:8], lbl};
  endfunction

  function automatic bit model_ok(input logic [31:0] w);
    bit lp = 0;
    for (int i = 0; i < 16; i++) if (labels[i] == w[7:0]) lp = 1;
    if (cfg_lbl_en && !lp) return 0;
    if (cfg_dec_en && (w[8] != cfg_dec_b9 || w[9] != cfg_dec_b10)) return 0;
    return 1;
  endfunction

  function automatic logic [15:0] exp_half(input logic [31:0] w, input bit sel, input bit plain);
    int mp [16] = '{13, 12, 11, 10, 9, 31, 30, 32, 1, 2, 3, 4, 5, 6, 7, 8};
    logic [15:0] r;
    for (int k = 0; k < 16; k++) begin
      if (plain) r[k] = w[sel ? 16 + k : k];
      else if (sel) r[k] = w[13 + k];
      else r[15 - k] = w[mp[k] - 1];
    end
    return r;
  endfunction

  task automatic send(input logic [31:0] w);
    @(negedge clk); rx_word = w; rx_eos = 1'b1;
    @(negedge clk); rx_eos = 1'b0;
    if (!cfg_lbl_mode && model_ok(w)) begin
      if (q.size() == 32) q[31] = w;
      else q.push_back(w);
    end
  endtask

  task automatic chk_flags(input string req);
    check(req, {29'd0, data_ready, half_full, full},
          {29'd0, q.size() > 0, q.size() >= 16, q.size() == 32});
  endtask

  task automatic read_half(input bit sel, output logic [15:0] d);
    @(negedge clk); host_sel = sel; host_rd = 1'b1;
    @(negedge clk); d = rd_data; host_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_word(input string req);
    logic [15:0] lo, hi;
    logic [31:0] w;
    read_half(1'b0, lo);
    read_half(1'b1, hi);
    w = q.pop_front();
    check({req, " first half"}, {16'd0, lo}, {16'd0, exp_half(w, 1'b0, cfg_plain)});
    check({req, " second half"}, {16'd0, hi}, {16'd0, exp_half(w, 1'b1, cfg_plain)});
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) read_word(req);
    chk_flags(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, d2;
    rst_n = 0; rx_word = 0; rx_eos = 0; cfg_lbl_en = 0; cfg_dec_en = 0;
    cfg_dec_b9 = 0; cfg_dec_b10 = 0; cfg_lbl_mode = 0; cfg_plain = 1;
    host_rd = 0; host_sel = 0; host_wr = 0; host_wdata = 0;
    for (int i = 0; i < 16; i++) labels[i] = (i == 5) ? 8'h00 : 8'(8'h20 + i * 9);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_flags("R12 reset flags");
    check("R12 reset rd_data", {16'd0, rd_data}, 32'd0);

    // R3: table load, one extra write must be ignored
    cfg_lbl_mode = 1; @(negedge clk); @(negedge clk);
    for (int i = 0; i < 17; i++) begin
      @(negedge clk); host_wdata = (i < 16) ? labels[i] : 8'hEE; host_wr = 1;
      @(negedge clk); host_wr = 0;
    end
    for (int i = 0; i < 16; i++) begin
      read_half(1'b0, d);
      check($sformatf("R3 R4 label entry %0d", i), {16'd0, d}, {24'd0, labels[i]});
    end
    cfg_lbl_mode = 0; @(negedge clk);

    // R2 R9 R8: no filters, plain layout
    for (int i = 0; i < 6; i++) begin send(gen(i, 8'(i * 37))); chk_flags("R7 plain fill"); end
    check("R2 all kept", q.size(), 6);
    read_half(1'b0, d); read_half(1'b0, d2);
    check("R8 first half repeat", {16'd0, d2}, {16'd0, d});
    drain("R9 R8 plain readout");

    // R1: label filter, labels cycling through hits and misses
    cfg_lbl_en = 1; cfg_plain = 0;
    for (int i = 0; i < 24; i++) begin
      send(gen(100 + i, (i % 3 == 0) ? labels[i % 16] : ((i % 3 == 1) ? 8'(8'hA0 + i) : 8'h00)));
    end
    chk_flags("R1 label filter count");
    drain("R1 R10 label filtered");

    // R2: decoder alone, then both filters
    cfg_lbl_en = 0; cfg_dec_en = 1; cfg_dec_b9 = 1; cfg_dec_b10 = 0;
    for (int i = 0; i < 16; i++) send(gen(200 + i, 8'(i)));
    chk_flags("R2 decoder count");
    drain("R2 decoder only");
    cfg_lbl_en = 1; cfg_dec_b9 = 0; cfg_dec_b10 = 1;
    for (int i = 0; i < 32; i++) send(gen(300 + i, (i % 2) ? labels[i % 16] : 8'hFF));
    chk_flags("R2 both filters count");
    drain("R2 both filters");

    // R6 R7 R10: overfill, scrambled readout
    cfg_lbl_en = 0; cfg_dec_en = 0;
    for (int i = 0; i < 35; i++) begin send(gen(400 + i, 8'(i))); chk_flags("R6 R7 fill level"); end
    check("R6 last entry is newest", q[31], gen(434, 8'd34));
    drain("R6 R10 overwrite readout");

    // R11: empty read holds data
    d = rd_data;
    read_half(1'b0, d2);
    check("R11 empty read hold", {16'd0, d2}, {16'd0, d});
    chk_flags("R11 empty flags");
    send(gen(500, 8'h11));
    drain("R11 after empty read");

    // R5: label mode freezes the queue
    send(gen(600, 8'h22));
    cfg_lbl_mode = 1; @(negedge clk);
    for (int i = 0; i < 3; i++) send(gen(610 + i, 8'h33));
    read_half(1'b1, d);
    chk_flags("R5 frozen in label mode");
    cfg_lbl_mode = 0; @(negedge clk);
    drain("R5 word survives label mode");

    // R12: reset clears queue, keeps labels
    for (int i = 0; i < 5; i++) send(gen(700 + i, 8'h44));
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    q.delete();
    chk_flags("R12 reset clears queue");
    cfg_lbl_en = 1; cfg_plain = 1;
    send(gen(800, labels[7])); send(gen(801, 8'hFE)); send(gen(802, labels[5]));
    check("R12 labels kept after reset", q.size(), 2);
    chk_flags("R12 flags after reset");
    drain("R12 R1 labels kept");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule